// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns the one-bit output of a sigma-delta modulator into signed 24-bit conversion results. A qualifying pulse on `mod_en` marks each modulator sample. Each sample enters a cascade of three integrators as +1 (bit high) or -1 (bit low). Once every R samples, three comb stages at the decimated rate produce a raw word. That word is normalised by R cubed and scaled, then rounded and clamped to the output range. The frequency response is a sinc-cubed low-pass whose nulls fall on whole multiples of the output word rate. Changing R moves the nulls and keeps the shape.

R comes from a 12-bit filter code, limited to the range 19 to 2000. A new code takes effect only at the end of the word in progress. At that point the filter history is wiped. Each result is announced by a one-cycle strobe and carries a valid flag. The flag stays low for four words after reset, after a ratio change, and after a channel-switch request. Nominal full scale is a bitstream density (ones fraction minus zeros fraction) of 0.8, and results may exceed it by 5% before they clamp.

The divider that normalises the result takes one system clock per quotient bit. A word boundary must therefore come at least 26 system clocks after the previous one. With the default parameters this holds when modulator pulses are at least two system clocks apart.

Top module: `sinc3_decim`

## Requirements
- R1: For a steady bitstream of density d, whose repeat length divides R, the settled result is d·9986436 rounded to the nearest integer, with halves rounded away from zero. Bit 1 counts +1 and bit 0 counts -1.
- R2: The ratio R equals the limited filter code. `res_rdy` pulses exactly once every R modulator enables, so the strobe period is R times the enable spacing.
- R3: Codes below 19 act as 19, and codes above 2000 act as 2000.
- R4: A code change is applied at the next word boundary. The word ending at that boundary is still produced. It is followed by exactly four words with `res_valid` low, then valid words from the new ratio.
- R5: A one-cycle `chan_sw` pulse (away from a boundary) makes exactly the next four words invalid. If the ratio also changes at the next boundary, the count becomes five.
- R6: While reset is held, `res_rdy`, `res_valid` and `res_data` are all 0. At least the first four words after reset are invalid.
- R7: Results saturate instead of wrapping. A density of magnitude above 0.84 (5% over nominal full scale) gives 8388607 (0x7FFFFF) or -8388608 (0x800000). A density of ±0.8 gives ±7989149 without clamping.
- R8: `res_rdy` is never high for two cycles in a row. `res_data` and `res_valid` change only on a cycle where `res_rdy` is high. Settling words still raise `res_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_en | input | 1 | One pulse per modulator sample |
| mod_bit | input | 1 | Modulator bit, sampled when `mod_en` is high |
| flt_code | input | 12 | Filter code selecting the decimation ratio |
| chan_sw | input | 1 | Channel-switch request, restarts settling |
| res_data | output | 24 | Two's complement result |
| res_valid | output | 1 | Result is settled |
| res_rdy | output | 1 | One-cycle strobe for each new result |

## Verification
The bench uses the default parameters: ratio limits 19 and 2000, a 36-bit accumulator, a settling span of four words, and a gain of 9986436. Modulator pulses arrive every second clock. Most steady-state patterns run at ratios 20, 24 and 40, where each output word takes only a few dozen clocks. This makes saturation, the 5% headroom edge, negative rounding and exact settling counts cheap to reach. One run at the clamped ratio of 2000 exercises the widest accumulator growth and the longest normalising division.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;

endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl #(
  parameter int CODE_W       = 12,
  parameter int RATIO_W      = 11,
  parameter int RATIO_MIN    = 19,
  parameter int RATIO_MAX    = 2000,
  parameter int SETTLE_WORDS = 4,
  parameter int SET_W        = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mod_en,
  input  logic [CODE_W-1:0]  code,
  input  logic               chan_sw,
  output logic [RATIO_W-1:0] ratio,
  output logic               word_end,
  output logic               flush,
  output logic               settled
);

  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [RATIO_W-1:0] phase_q, phase_d;
  logic [RATIO_W-1:0] code_lim;
  logic [SET_W-1:0]   settle_q, settle_d;

  // limit the requested code to the supported ratio range
  always_comb begin
    if (code < CODE_W'(RATIO_MIN))      code_lim = RATIO_W'(RATIO_MIN);
    else if (code > CODE_W'(RATIO_MAX)) code_lim = RATIO_W'(RATIO_MAX);
    else                                code_lim = code[RATIO_W-1:0];
  end

  always_comb begin
    word_end = mod_en && (phase_q == (ratio_q - RATIO_W'(1)));
    flush    = word_end && (code_lim != ratio_q);
    settled  = (settle_q == SET_W'(SETTLE_WORDS));

    phase_d = phase_q;
    if (mod_en) phase_d = word_end ? '0 : phase_q + RATIO_W'(1);

    ratio_d = flush ? code_lim : ratio_q;

    settle_d = settle_q;
    if (chan_sw || flush)
      settle_d = '0;
    else if (word_end && !settled)
      settle_d = settle_q + SET_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q  <= RATIO_W'(RATIO_MIN);
      phase_q  <= '0;
      settle_q <= '0;
    end else begin
      ratio_q  <= ratio_d;
      phase_q  <= phase_d;
      settle_q <= settle_d;
    end
  end

  assign ratio = ratio_q;

  p_ratio_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q >= RATIO_W'(RATIO_MIN)) && (ratio_q <= RATIO_W'(RATIO_MAX)));

  p_phase_in_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < ratio_q);

  p_flush_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (settle_q == '0) && (phase_q == '0));

  p_switch_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sw |=> (settle_q == '0));

endmodule

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] acc_out
);

  logic signed [ACC_W-1:0] acc_q [ORDER];
  logic signed [ACC_W-1:0] acc_d [ORDER];
  logic signed [ACC_W-1:0] stg_in [ORDER];

  always_comb begin
    stg_in[0] = bit_in ? ACC_W'(1) : '1;
    for (int k = 1; k < ORDER; k++) stg_in[k] = acc_q[k-1];
    for (int k = 0; k < ORDER; k++) acc_d[k] = clr ? '0 : acc_q[k] + stg_in[k];
  end

  generate
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc_q[g] <= '0;
        else if (en) acc_q[g] <= acc_d[g];
      end
    end
  endgenerate

  assign acc_out = acc_q[ORDER-1];

  p_clear_zeroes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> (acc_out == '0));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);

  logic signed [ACC_W-1:0] dly_q [ORDER];
  logic signed [ACC_W-1:0] dly_d [ORDER];
  logic signed [ACC_W-1:0] diff  [ORDER];

  always_comb begin
    diff[0]  = din - dly_q[0];
    dly_d[0] = clr ? '0 : din;
    for (int k = 1; k < ORDER; k++) begin
      diff[k]  = diff[k-1] - dly_q[k];
      dly_d[k] = clr ? '0 : diff[k-1];
    end
  end

  generate
    for (genvar g = 0; g < ORDER; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  dly_q[g] <= '0;
        else if (en) dly_q[g] <= dly_d[g];
      end
    end
  endgenerate

  assign dout = diff[ORDER-1];

  p_hold_off_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dly_q[0]));

endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale
  import sinc3_pkg::*;
#(
  parameter int ORDER   = 3,
  parameter int ACC_W   = 36,
  parameter int OUT_W   = 24,
  parameter int RATIO_W = 11,
  parameter int GAIN    = 9986436
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] raw,
  input  logic [RATIO_W-1:0]      ratio,
  input  logic                    tag_ok,
  output logic [OUT_W-1:0]        res_data,
  output logic                    res_valid,
  output logic                    res_rdy
);

  localparam int GAIN_W = $clog2(GAIN + 1);
  localparam int DEN_W  = ORDER * RATIO_W;
  localparam int NUM_W  = ACC_W + GAIN_W;
  localparam int IT_W   = $clog2(GAIN_W);
  localparam logic [OUT_W:0] POS_LIM = {2'b00, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W:0] NEG_LIM = {2'b01, {(OUT_W-1){1'b0}}};

  div_state_e         state_q, state_d;
  logic [IT_W-1:0]    it_q, it_d;
  logic [NUM_W-1:0]   rem_q, rem_d;
  logic [NUM_W-1:0]   dsh_q, dsh_d;
  logic [GAIN_W-1:0]  quo_q, quo_d;
  logic               neg_q, neg_d;
  logic               tag_q, tag_d;
  logic [OUT_W-1:0]   data_q, data_d;
  logic               valid_q, valid_d;
  logic               rdy_q, rdy_d;

  logic [ACC_W-1:0]   mag;
  logic [DEN_W-1:0]   den;
  logic               ge;
  logic [OUT_W:0]     qx;

  always_comb begin
    mag = raw[ACC_W-1] ? ACC_W'(-raw) : ACC_W'(raw);
    den = DEN_W'(1);
    for (int k = 0; k < ORDER; k++) den = den * DEN_W'(ratio);
  end

  always_comb begin
    state_d = state_q;
    it_d    = it_q;
    rem_d   = rem_q;
    dsh_d   = dsh_q;
    quo_d   = quo_q;
    neg_d   = neg_q;
    tag_d   = tag_q;
    data_d  = data_q;
    valid_d = valid_q;
    rdy_d   = 1'b0;
    ge      = rem_q >= dsh_q;
    qx      = '0;

    unique case (state_q)
      DIV_IDLE: begin
        if (start) begin
          state_d = DIV_RUN;
          it_d    = IT_W'(GAIN_W - 1);
          rem_d   = NUM_W'(mag) * NUM_W'(GAIN) + NUM_W'(den >> 1);
          dsh_d   = NUM_W'(den) << (GAIN_W - 1);
          quo_d   = '0;
          neg_d   = raw[ACC_W-1];
          tag_d   = tag_ok;
        end
      end
      DIV_RUN: begin
        rem_d = ge ? rem_q - dsh_q : rem_q;
        dsh_d = dsh_q >> 1;
        quo_d = GAIN_W'({quo_q, ge});
        it_d  = it_q - IT_W'(1);
        if (it_q == '0) begin
          state_d = DIV_IDLE;
          rdy_d   = 1'b1;
          valid_d = tag_q;
          qx      = (OUT_W+1)'(quo_d);
          if (!neg_q) data_d = (qx > POS_LIM) ? POS_LIM[OUT_W-1:0] : qx[OUT_W-1:0];
          else        data_d = (qx > NEG_LIM) ? NEG_LIM[OUT_W-1:0] : OUT_W'(-qx[OUT_W-1:0]);
        end
      end
      default: state_d = DIV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      it_q    <= '0;
      rem_q   <= '0;
      dsh_q   <= '0;
      quo_q   <= '0;
      neg_q   <= 1'b0;
      tag_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      it_q    <= it_d;
      rem_q   <= rem_d;
      dsh_q   <= dsh_d;
      quo_q   <= quo_d;
      neg_q   <= neg_d;
      tag_q   <= tag_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      rdy_q   <= rdy_d;
    end
  end

  assign res_data  = data_q;
  assign res_valid = valid_q;
  assign res_rdy   = rdy_q;

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);

  p_data_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> rdy_q);

  p_valid_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(valid_q) |-> rdy_q);

  p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state_q == DIV_IDLE));

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int CODE_W       = 12,
  parameter int RATIO_MIN    = 19,
  parameter int RATIO_MAX    = 2000,
  parameter int ORDER        = 3,
  parameter int ACC_W        = 36,
  parameter int OUT_W        = 24,
  parameter int SETTLE_WORDS = 4,
  parameter int GAIN         = 9986436
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              mod_bit,
  input  logic [CODE_W-1:0] flt_code,
  input  logic              chan_sw,
  output logic [OUT_W-1:0]  res_data,
  output logic              res_valid,
  output logic              res_rdy
);

  localparam int RATIO_W = $clog2(RATIO_MAX + 1);
  localparam int SET_W   = $clog2(SETTLE_WORDS + 1);

  logic [1:0]              rs_q;
  logic                    rst_s;
  logic [RATIO_W-1:0]      ratio;
  logic                    word_end, flush, settled;
  logic signed [ACC_W-1:0] integ_out, comb_out;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  sinc3_ctrl #(
    .CODE_W(CODE_W), .RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN),
    .RATIO_MAX(RATIO_MAX), .SETTLE_WORDS(SETTLE_WORDS), .SET_W(SET_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s), .mod_en(mod_en), .code(flt_code),
    .chan_sw(chan_sw), .ratio(ratio), .word_end(word_end),
    .flush(flush), .settled(settled)
  );

  sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_s), .en(mod_en), .clr(flush),
    .bit_in(mod_bit), .acc_out(integ_out)
  );

  sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_s), .en(word_end), .clr(flush),
    .din(integ_out), .dout(comb_out)
  );

  sinc3_scale #(
    .ORDER(ORDER), .ACC_W(ACC_W), .OUT_W(OUT_W),
    .RATIO_W(RATIO_W), .GAIN(GAIN)
  ) u_scale (
    .clk(clk), .rst_n(rst_s), .start(word_end), .raw(comb_out),
    .ratio(ratio), .tag_ok(settled), .res_data(res_data),
    .res_valid(res_valid), .res_rdy(res_rdy)
  );

endmodule

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;

  typedef struct packed {
    int          code;
    logic [31:0] pat;
    int          per;
    int          exp;
    int          ninv;
  } vec_t;

  localparam int NV = 9;
  // steady patterns after a channel switch: R1 values, R7 clamps, R9-style rounding
  localparam vec_t TBL [NV] = '{
    '{20, 32'h1,     1,  8388607, 4},
    '{20, 32'h0,     1, -8388608, 4},
    '{20, 32'h1,     2,        0, 4},
    '{20, 32'h7,     4,  4993218, 4},
    '{20, 32'h1FF,  10,  7989149, 4},
    '{20, 32'h1,    10, -7989149, 4},
    '{20, 32'hF,     5,  5991862, 4},
    '{40, 32'h7FFFF,20,  8388607, 5},
    '{40, 32'h1,     4, -4993218, 4}
  };

  logic        clk, rst_n, mod_en, mod_bit, chan_sw;
  logic [11:0] flt_code;
  logic [23:0] res_data;
  logic        res_valid, res_rdy;

  int     n_chk = 0, n_bad = 0;
  longint cyc = 0;
  logic [31:0] pat;
  int     per, pidx;
  int     last_d;
  logic   last_v;
  longint last_cyc;
  int     dbl_rdy = 0, stray_chg = 0;

  sinc3_decim u0 (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .flt_code(flt_code), .chan_sw(chan_sw), .res_data(res_data),
    .res_valid(res_valid), .res_rdy(res_rdy)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // modulator: one sample every second clock
  initial begin
    mod_en = 1'b0; mod_bit = 1'b0;
    forever begin
      @(negedge clk);
      if (mod_en) mod_en = 1'b0;
      else begin
        mod_en  = 1'b1;
        mod_bit = pat[pidx];
        pidx    = (pidx + 1) % per;
      end
    end
  end

  // R8 monitor
  initial begin
    logic       prev_rdy;
    logic [23:0] prev_d;
    logic       prev_v;
    prev_rdy = 1'b0; prev_d = '0; prev_v = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (res_rdy && prev_rdy) dbl_rdy++;
        if (!res_rdy && ((res_data != prev_d) || (res_valid != prev_v))) stray_chg++;
      end
      prev_rdy = res_rdy; prev_d = res_data; prev_v = res_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_word();
    forever begin
      @(negedge clk);
      if (res_rdy) break;
    end
    last_d   = int'($signed(res_data));
    last_v   = res_valid;
    last_cyc = cyc;
  endtask

  task automatic wait_valid(output int ninv);
    ninv = 0;
    wait_word();
    while (!last_v && ninv < 30) begin
      ninv++;
      wait_word();
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int     ninv;
    longint t1;
    rst_n = 1'b0; chan_sw = 1'b0; flt_code = 12'd20;
    pat = 32'h1; per = 1; pidx = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(res_rdy == 1'b0,   "R6", "rdy in reset",   res_rdy, 0);
    chk(res_valid == 1'b0, "R6", "valid in reset", res_valid, 0);
    chk(res_data == '0,    "R6", "data in reset",  res_data, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    wait_valid(ninv);
    chk(ninv >= 4, "R6", "invalid words after reset", ninv, 4);
    chk(last_d == 8388607, "R7", "all-ones clamp after reset", last_d, 8388607);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      flt_code = TBL[i].code[11:0];
      pat = TBL[i].pat; per = TBL[i].per; pidx = 0;
      chan_sw = 1'b1;
      @(posedge clk); #1 chan_sw = 1'b0;
      wait_valid(ninv);
      chk(ninv == TBL[i].ninv, "R5", "invalid words after switch", ninv, TBL[i].ninv);
      chk(last_d == TBL[i].exp, "R1 R7", "settled value", last_d, TBL[i].exp);
      wait_word();
      chk(last_v && last_d == TBL[i].exp, "R1", "next settled value", last_d, TBL[i].exp);
    end

    // R4: code change without channel switch
    @(posedge clk); #1;
    flt_code = 12'd24; pat = 32'h1; per = 2; pidx = 0;
    wait_word();
    wait_valid(ninv);
    chk(ninv == 4, "R4", "invalid words after code change", ninv, 4);
    chk(last_d == 0, "R4", "value at new ratio", last_d, 0);
    wait_word(); t1 = last_cyc;
    wait_word();
    chk(last_cyc - t1 == 48, "R2", "strobe period at ratio 24", last_cyc - t1, 48);

    // R3: low clamp
    @(posedge clk); #1 flt_code = 12'd3;
    wait_word();
    wait_valid(ninv);
    chk(ninv == 4, "R3", "invalid words at clamped low code", ninv, 4);
    wait_word(); t1 = last_cyc;
    wait_word();
    chk(last_cyc - t1 == 38, "R3", "period for code 3", last_cyc - t1, 38);

    // R3: high clamp, widest growth
    @(posedge clk); #1;
    flt_code = 12'd4095; pat = 32'h7; per = 4; pidx = 0;
    wait_word();
    wait_valid(ninv);
    chk(ninv == 4, "R3", "invalid words at clamped high code", ninv, 4);
    chk(last_d == 4993218, "R1", "value at ratio 2000", last_d, 4993218);
    t1 = last_cyc;
    wait_word();
    chk(last_cyc - t1 == 4000, "R3", "period for code 4095", last_cyc - t1, 4000);

    chk(dbl_rdy == 0,   "R8", "strobe longer than one cycle", dbl_rdy, 0);
    chk(stray_chg == 0, "R8", "output change without strobe", stray_chg, 0);

    summary();
    $finish;
  end

endmodule